// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset causes into one internal active-low reset with a fixed assertion and release order. The causes are an external active-low reset pin, an address-trap request, a watchdog request and a clock-failure request. The pin first passes through a synchronizer. It counts as a reset only after it has stayed low long enough. The three internal malfunction requests are single-cycle pulses, and each is stretched to a fixed reset window. Every path then runs a common stabilisation count before reset is released.

When reset is released, the block gives a one-cycle fetch strobe that carries the reset-vector address. It also keeps a sticky cause register, which software clears by writing ones. The block holds the interrupt master enable low for as long as reset is active. An asynchronous power-on input overrides everything else: it clears the cause register and starts a full stabilisation count.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_n` is low, `sys_rst_n`, `ime` and `cause` are forced to 0 without waiting for a clock. Counting from the first clock edge after `por_n` rises, reset stays low for 1024 cycles.
- R2: `ext_rst_n` is resynchronised through two flops. It raises a reset only after it has been seen low on 12 consecutive clock edges. A shorter low pulse is ignored, including during an ongoing sequence.
- R3: An accepted pin reset holds `sys_rst_n` low while the pin stays low. If the pin is low for L clocks (L ≥ 12), reset is low for L − 11 + 1024 cycles in total.
- R4: A one-cycle trap, watchdog or clock-failure request holds reset low for 24 cycles and then for 1024 more, which is 1048 cycles in total.
- R5: A new request arriving during the stretch or the stabilisation count restarts the sequence. This applies to a malfunction request and to a qualified pin reset, and the duration is then measured from the first trigger.
- R6: In the first cycle that `sys_rst_n` is high, `vec_fetch` is high for exactly one cycle and `vec_addr` equals 0xFFFE. At all other times `vec_addr` is 0.
- R7: `ime` is 0 whenever `sys_rst_n` is low, and a write to it during reset has no effect. Outside reset, `ime_wr` loads `ime_wdata`.
- R8: The `cause` bits are bit 0 for the pin, bit 1 for trap, bit 2 for watchdog and bit 3 for clock failure. A source that triggers or restarts a sequence sets its own bit. Bits build up until they are cleared.
- R9: Writing `cause_w1c` clears each bit written as 1 and leaves the bits written as 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| trap_req | input | 1 | Address-trap reset request pulse |
| wdog_req | input | 1 | Watchdog reset request pulse |
| clkfail_req | input | 1 | Clock-failure reset request pulse |
| ime_wr | input | 1 | Write strobe for interrupt master enable |
| ime_wdata | input | 1 | Value written to interrupt master enable |
| cause_w1c | input | 4 | Write-one-to-clear mask for the cause register |
| sys_rst_n | output | 1 | Internal reset, active low |
| ime | output | 1 | Interrupt master enable |
| vec_fetch | output | 1 | One-cycle reset-vector fetch strobe |
| vec_addr | output | 16 | Reset-vector address while strobing, else 0 |
| cause | output | 4 | Sticky reset-cause bits |

## Verification
The pin is driven low for 11 clocks to test rejection, for exactly 12 clocks to test the acceptance edge, and for 30 clocks to show that reset follows the pin's release and not its fall. The malfunction requests are tried in four ways: singly, all in the same cycle, as a second request well inside the stabilisation count, and with a too-short pin pulse during stabilisation. These cases separate a restart from an ignored event by the exact reset length. A pin reset that arrives during stabilisation shows that pin qualification restarts the sequence. Two power-on pulses, the second one with a cause already recorded, separate asynchronous clearing from the normal sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_EXT_HOLD = 2'd1,
      ST_STRETCH  = 2'd2,
      ST_STABLE   = 2'd3
   } seq_state_t;

   localparam int SRC_N    = 4;
   localparam int SRC_EXT  = 0;
   localparam int SRC_TRAP = 1;
   localparam int SRC_WDOG = 2;
   localparam int SRC_CLK  = 3;

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 12
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic pin_s,
   output logic qual
);
   localparam int LW = $clog2(MIN_LOW);
   localparam logic [LW-1:0] LOW_LAST = LW'(MIN_LOW - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_pin_qual: SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW < 2) begin : g_bad_low
      $error("rst_pin_qual: MIN_LOW must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            chain[i] <= 1'b1;
         end else begin
            if (i == 0) chain[i] <= pin_n;
            else        chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign pin_s = chain[SYNC_STAGES-1];

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         low_cnt <= '0;
      end else if (pin_s) begin
         low_cnt <= '0;
      end else if (low_cnt != LOW_LAST) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign qual = !pin_s && (low_cnt == LOW_LAST);

   // R2: acceptance needs the synchronised pin low on the previous cycle too
   p_qual_needs_history_r2: assert property (@(posedge clk) disable iff (!por_n)
      qual |-> $past(!pin_s));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
   import rst_seq_pkg::*;
#(
   parameter int          FAULT_PULSE = 24,
   parameter int          STAB_LOG2   = 10,
   parameter int          ADDR_W      = 16,
   parameter int unsigned VEC_ADDR    = 32'h0000_FFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_s,
   input  logic              ext_qual,
   input  logic [2:0]        fault_req,
   output logic              rst_n,
   output logic              rst_next,
   output logic [SRC_N-1:0]  cause_set,
   output logic              vec_fetch,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam int FW    = (FAULT_PULSE > 1) ? $clog2(FAULT_PULSE) : 1;
   localparam int CNT_W = (STAB_LOG2 > FW) ? STAB_LOG2 : FW;
   localparam logic [CNT_W-1:0] FLT_LAST  = CNT_W'(FAULT_PULSE - 1);
   localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'((64'd1 << STAB_LOG2) - 1);

   if (FAULT_PULSE < 1) begin : g_bad_pulse
      $error("rst_seq_fsm: FAULT_PULSE must be at least 1");
   end
   if (STAB_LOG2 < 1 || STAB_LOG2 > 24) begin : g_bad_stab
      $error("rst_seq_fsm: STAB_LOG2 out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("rst_seq_fsm: ADDR_W out of range");
   end

   seq_state_t       state, state_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             fetch_q, fetch_n;

   always_comb begin
      state_n   = state;
      cnt_n     = cnt;
      cause_set = '0;
      fetch_n   = 1'b0;
      unique case (state)
         ST_RUN: begin
            if (ext_qual) begin
               state_n            = ST_EXT_HOLD;
               cause_set[SRC_EXT] = 1'b1;
            end else if (|fault_req) begin
               state_n   = ST_STRETCH;
               cnt_n     = '0;
               cause_set = {fault_req, 1'b0};
            end
         end
         ST_EXT_HOLD: begin
            if (ext_s) begin
               state_n = ST_STABLE;
               cnt_n   = '0;
            end
         end
         default: begin
            if (ext_qual) begin
               state_n            = ST_EXT_HOLD;
               cause_set[SRC_EXT] = 1'b1;
            end else if (|fault_req) begin
               state_n   = ST_STRETCH;
               cnt_n     = '0;
               cause_set = {fault_req, 1'b0};
            end else if (state == ST_STRETCH) begin
               if (cnt == FLT_LAST) begin
                  state_n = ST_STABLE;
                  cnt_n   = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end else begin
               if (cnt == STAB_LAST) begin
                  state_n = ST_RUN;
                  fetch_n = 1'b1;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state   <= ST_STABLE;
         cnt     <= '0;
         fetch_q <= 1'b0;
      end else begin
         state   <= state_n;
         cnt     <= cnt_n;
         fetch_q <= fetch_n;
      end
   end

   assign rst_n     = (state == ST_RUN);
   assign rst_next  = (state_n != ST_RUN);
   assign vec_fetch = fetch_q;
   assign vec_addr  = fetch_q ? ADDR_W'(VEC_ADDR) : '0;

   // R6: strobe lasts a single cycle
   p_fetch_single_r6: assert property (@(posedge clk) disable iff (!por_n)
      fetch_q |=> !fetch_q);

   // R6: release is always accompanied by the strobe
   p_fetch_on_release_r6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_n) |-> fetch_q);

   // R5: a malfunction request outside pin hold restarts the stretch window
   p_fault_restart_r5: assert property (@(posedge clk) disable iff (!por_n)
      ((|fault_req) && !ext_qual && state != ST_EXT_HOLD)
         |=> (state == ST_STRETCH && cnt == '0));

   // R4: the stretch counter never runs past its window
   p_stretch_window_r4: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_STRETCH) |-> (cnt <= FLT_LAST));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] w1c,
   output logic [N-1:0] cause
);
   if (N < 1) begin : g_bad_n
      $error("rst_cause_reg: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)      cause[i] <= 1'b0;
         else if (set[i]) cause[i] <= 1'b1;
         else if (w1c[i]) cause[i] <= 1'b0;
      end

      // R9: a written one clears its bit unless a set collides
      p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
         ($past(w1c[i]) && !$past(set[i])) |-> !cause[i]);

      // R8: a triggering source always leaves its bit set
      p_set_sticks_r8: assert property (@(posedge clk) disable iff (!por_n)
         set[i] |=> cause[i]);
   end

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
   import rst_seq_pkg::*;
#(
   parameter int          SYNC_STAGES  = 2,
   parameter int          MCYC_CLKS    = 4,
   parameter int          MIN_LOW_MCYC = 3,
   parameter int          FAULT_PULSE  = 24,
   parameter int          STAB_LOG2    = 10,
   parameter int          ADDR_W       = 16,
   parameter int unsigned VEC_ADDR     = 32'h0000_FFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst_n,
   input  logic              trap_req,
   input  logic              wdog_req,
   input  logic              clkfail_req,
   input  logic              ime_wr,
   input  logic              ime_wdata,
   input  logic [3:0]        cause_w1c,
   output logic              sys_rst_n,
   output logic              ime,
   output logic              vec_fetch,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [3:0]        cause
);
   localparam int MIN_LOW = MCYC_CLKS * MIN_LOW_MCYC;

   if (MCYC_CLKS < 1 || MIN_LOW_MCYC < 1) begin : g_bad_mcyc
      $error("rst_seq_top: machine-cycle parameters must be positive");
   end

   logic             ext_s, ext_qual, rst_next;
   logic [SRC_N-1:0] cause_set;
   logic [2:0]       fault_req;

   assign fault_req = {clkfail_req, wdog_req, trap_req};

   rst_pin_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_LOW     (MIN_LOW)
   ) u_pin (
      .clk   (clk),
      .por_n (por_n),
      .pin_n (ext_rst_n),
      .pin_s (ext_s),
      .qual  (ext_qual)
   );

   rst_seq_fsm #(
      .FAULT_PULSE (FAULT_PULSE),
      .STAB_LOG2   (STAB_LOG2),
      .ADDR_W      (ADDR_W),
      .VEC_ADDR    (VEC_ADDR)
   ) u_fsm (
      .clk       (clk),
      .por_n     (por_n),
      .ext_s     (ext_s),
      .ext_qual  (ext_qual),
      .fault_req (fault_req),
      .rst_n     (sys_rst_n),
      .rst_next  (rst_next),
      .cause_set (cause_set),
      .vec_fetch (vec_fetch),
      .vec_addr  (vec_addr)
   );

   rst_cause_reg #(.N(SRC_N)) u_cause (
      .clk   (clk),
      .por_n (por_n),
      .set   (cause_set),
      .w1c   (cause_w1c),
      .cause (cause)
   );

   logic ime_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        ime_q <= 1'b0;
      else if (rst_next) ime_q <= 1'b0;
      else if (ime_wr)   ime_q <= ime_wdata;
   end

   assign ime = ime_q;

   // R7: interrupts stay disabled whenever reset is active
   p_ime_off_in_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |-> !ime);

endmodule

// File: tb/tb_rst_seq_top.sv
`timescale 1ns/100ps
module tb_rst_seq_top;
   localparam int SYNC   = 2;
   localparam int MINLOW = 12;
   localparam int FPULSE = 24;
   localparam int STAB   = 1024;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, ext_rst_n = 1'b1;
   logic        trap_req = 1'b0, wdog_req = 1'b0, clkfail_req = 1'b0;
   logic        ime_wr = 1'b0, ime_wdata = 1'b0;
   logic [3:0]  cause_w1c = 4'h0;
   logic        sys_rst_n, ime, vec_fetch;
   logic [15:0] vec_addr;
   logic [3:0]  cause;

   always #2.5 clk = ~clk;

   rst_seq_top dut (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .trap_req(trap_req),
      .wdog_req(wdog_req), .clkfail_req(clkfail_req), .ime_wr(ime_wr),
      .ime_wdata(ime_wdata), .cause_w1c(cause_w1c), .sys_rst_n(sys_rst_n),
      .ime(ime), .vec_fetch(vec_fetch), .vec_addr(vec_addr), .cause(cause)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   typedef struct { int dur; logic [3:0] cause; string rq; } exp_t;
   exp_t sb[$];
   exp_t e;

   // monitor: measures each reset window and compares with the scoreboard
   int lowcnt = 0;
   bit ime_bad = 0;
   always @(negedge clk) begin
      if (!por_n) begin
         lowcnt  = 0;
         ime_bad = 0;
      end else if (!sys_rst_n) begin
         lowcnt++;
         if (ime) ime_bad = 1;
      end else if (lowcnt > 0) begin
         if (sb.size() == 0) begin
            chk("R5 unexpected release", 1, 0);
         end else begin
            e = sb.pop_front();
            chk({e.rq, " reset length"}, lowcnt, e.dur);
            chk("R8 cause on release", int'(cause), int'(e.cause));
            chk("R6 fetch strobe", int'(vec_fetch), 1);
            chk("R6 vector address", int'(vec_addr), 'hFFFE);
            chk("R7 ime low during reset", int'(ime_bad), 0);
         end
         lowcnt  = 0;
         ime_bad = 0;
      end else begin
         if (vec_fetch)       chk("R6 stray strobe", 1, 0);
         if (vec_addr != 0)   chk("R6 idle address", int'(vec_addr), 0);
      end
   end

   task automatic push(input int dur, input logic [3:0] c, input string rq);
      exp_t x;
      x.dur = dur; x.cause = c; x.rq = rq;
      sb.push_back(x);
   endtask

   task automatic wait_release();
      @(posedge sys_rst_n);
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_pin(input int len);
      @(negedge clk) ext_rst_n = 1'b0;
      repeat (len) @(negedge clk);
      ext_rst_n = 1'b1;
   endtask

   task automatic w1c(input logic [3:0] m);
      @(negedge clk) cause_w1c = m;
      @(negedge clk) cause_w1c = 4'h0;
   endtask

   task automatic do_por(input string rq);
      @(negedge clk) por_n = 1'b0;
      #1;
      chk({rq, " async reset low"}, int'(sys_rst_n), 0);
      chk({rq, " async cause clear"}, int'(cause), 0);
      chk({rq, " async ime clear"}, int'(ime), 0);
      push(STAB, 4'h0, rq);
      repeat (2) @(posedge clk);
      #1 por_n = 1'b1;
      wait_release();
   endtask

   initial begin
      bit ok;
      // R1: reset state while power-on is held
      @(negedge clk);
      chk("R1 reset state sys_rst_n", int'(sys_rst_n), 0);
      chk("R1 reset state ime", int'(ime), 0);
      chk("R1 reset state cause", int'(cause), 0);
      chk("R6 reset state strobe", int'(vec_fetch), 0);
      push(STAB, 4'h0, "R1 power-on");
      @(posedge clk);
      #1 por_n = 1'b1;
      wait_release();

      // R7: ime writable outside reset
      @(negedge clk) begin ime_wr = 1; ime_wdata = 1; end
      @(negedge clk) ime_wr = 0;
      chk("R7 ime write outside reset", int'(ime), 1);

      // R2/R3: pin low exactly at the limit
      push(1 + STAB, 4'h1, "R3 pin low 12");
      pulse_pin(MINLOW);
      wait_release();
      w1c(4'hF);
      chk("R9 clear all", int'(cause), 0);

      // R2: one clock short is ignored
      pulse_pin(MINLOW - 1);
      ok = 1;
      repeat (40) @(negedge clk) if (!sys_rst_n) ok = 0;
      chk("R2 short pin pulse ignored", int'(ok), 1);
      chk("R2 no cause from short pulse", int'(cause), 0);

      // R3: long pin low, release follows the pin
      push(30 - (MINLOW - 1) + STAB, 4'h1, "R3 pin low 30");
      pulse_pin(30);
      wait_release();
      w1c(4'hF);

      // R4/R7: watchdog stretch, ime write during reset ignored
      push(FPULSE + STAB, 4'h4, "R4 watchdog");
      @(negedge clk) wdog_req = 1;
      @(negedge clk) wdog_req = 0;
      repeat (50) @(negedge clk);
      ime_wr = 1; ime_wdata = 1;
      @(negedge clk) ime_wr = 0;
      chk("R7 ime write ignored in reset", int'(ime), 0);
      wait_release();
      chk("R7 ime cleared by reset", int'(ime), 0);
      w1c(4'hF);

      // R5: clock failure during stabilisation restarts
      push(200 + FPULSE + STAB, 4'hA, "R5 restart by fault");
      @(negedge clk) trap_req = 1;
      @(negedge clk) trap_req = 0;
      repeat (199) @(negedge clk);
      clkfail_req = 1;
      @(negedge clk) clkfail_req = 0;
      wait_release();
      w1c(4'hF);

      // R2: short pin pulse during stabilisation does not disturb it
      push(FPULSE + STAB, 4'h8, "R2 short pulse mid-sequence");
      @(negedge clk) clkfail_req = 1;
      @(negedge clk) clkfail_req = 0;
      repeat (300) @(negedge clk);
      pulse_pin(6);
      wait_release();
      w1c(4'hF);

      // R4/R8/R9: all malfunction sources together, partial clear
      push(FPULSE + STAB, 4'hE, "R4 all faults");
      @(negedge clk) begin trap_req = 1; wdog_req = 1; clkfail_req = 1; end
      @(negedge clk) begin trap_req = 0; wdog_req = 0; clkfail_req = 0; end
      wait_release();
      w1c(4'h2);
      chk("R9 partial clear", int'(cause), 'hC);
      w1c(4'hF);

      // R5: qualified pin during stabilisation restarts
      push(100 + MINLOW + SYNC + STAB, 4'h5, "R5 restart by pin");
      @(negedge clk) wdog_req = 1;
      @(negedge clk) wdog_req = 0;
      repeat (99) @(negedge clk);
      ext_rst_n = 0;
      repeat (MINLOW) @(negedge clk);
      ext_rst_n = 1;
      wait_release();

      // R1: power-on mid-run clears a recorded cause
      push(FPULSE + STAB, 4'h5 | 4'h4, "R8 accumulate");
      @(negedge clk) wdog_req = 1;
      @(negedge clk) wdog_req = 0;
      wait_release();
      do_por("R1 second power-on");
      chk("R1 cause after power-on", int'(cause), 0);
      chk("R5 scoreboard drained", sb.size(), 0);

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         chk("watchdog expired", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule